// File: doc/BRIEF.md
# Output Voltage Fault and Power-Good Supervisor

This block sits behind the analog comparators of a switching regulator's output and turns four digital window flags into three decisions: a power-good indication, a latched overvoltage shutdown and a latched undervoltage shutdown. The flags say whether the output is more than 10% high, more than 10% low, 30% or more low, and at or above 90% of target. Every decision waits until its condition has held for a fixed qualification time, `FILT` clock cycles. For example, 500 cycles at 100 MHz gives 5 µs.

Power-good stays low until soft start has finished and the output is in its window. It drops when the output leaves the window long enough. An overvoltage fault forces the low-side switch on. An undervoltage fault, which is only watched once soft start is over, floats both drivers. Either fault stops the controller and holds until enable goes low or the supply lockout signal drops.

Top module: `out_supervisor`

## Requirements
- R1: While `rst_n` is low, or while `enable` or `supply_ok` is low, `pgood`, `ls_force_on`, `drv_tristate` and `ctrl_off` are all 0.
- R2: `pgood` goes to 1 only after `soft_done`=1, `flag_reach`=1, `flag_over`=0 and `flag_low`=0 have held at `FILT` consecutive rising edges. It changes at the `FILT`-th such edge. With `soft_done`=0 it never rises.
- R3: Once `pgood` is 1, it goes to 0 at the `FILT`-th consecutive edge at which the good condition of R2 is false (for example `flag_low`=1 or `flag_over`=1).
- R4: A condition that lapses before `FILT` consecutive edges restarts its count from zero and changes nothing.
- R5: `flag_over`=1 held for `FILT` edges sets `ls_force_on` and `ctrl_off` at the next edge (edge `FILT`+1). `drv_tristate` stays 0.
- R6: `flag_under`=1 with `soft_done`=1 held for `FILT` edges sets `drv_tristate` and `ctrl_off` at edge `FILT`+1. `ls_force_on` stays 0.
- R7: `flag_under` has no effect while `soft_done` is 0.
- R8: If overvoltage and undervoltage qualify at the same edge, only `ls_force_on` is set. The two fault outputs are never 1 together.
- R9: A latched fault stays set after its flag clears, and `pgood` is 0 while `ctrl_off` is 1.
- R10: `enable` or `supply_ok` low at a single edge clears both fault latches at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low clears faults |
| supply_ok | input | 1 | Supply above lockout; low clears faults |
| soft_done | input | 1 | Soft start finished |
| flag_over | input | 1 | Output more than 10% above target |
| flag_low | input | 1 | Output more than 10% below target |
| flag_under | input | 1 | Output 30% or more below target |
| flag_reach | input | 1 | Output at or above 90% of target |
| pgood | output | 1 | Power good (1 = release the open-drain line) |
| ls_force_on | output | 1 | Latched overvoltage: hold low-side switch on |
| drv_tristate | output | 1 | Latched undervoltage: float both drivers |
| ctrl_off | output | 1 | Controller latched off by either fault |

## Verification
If a filter counter is stuck or does not restart, the port shows it within one qualification window: `pgood` or a fault output moves one or more edges earlier or later than edge `FILT` or `FILT`+1, or it moves after a glitch shorter than the window. A latch that is set wrongly or fails to clear is seen on the edge after the bad set or clear. It also blocks `pgood` for as long as it stays set. The directed cases pin the exact edge counts. The random phase compares every cycle against an edge-by-edge model, so a wrong state is caught in the cycle it first reaches a port.

// File: rtl/out_supervisor.sv
module out_supervisor #(
  parameter int FILT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic supply_ok,
  input  logic soft_done,
  input  logic flag_over,
  input  logic flag_low,
  input  logic flag_under,
  input  logic flag_reach,
  output logic pgood,
  output logic ls_force_on,
  output logic drv_tristate,
  output logic ctrl_off
);
  localparam int CW = $clog2(FILT + 1);
  localparam int NF = 3;

  wire clr = !enable || !supply_ok;

  logic [NF-1:0] raw, q;
  assign raw[0] = flag_over;
  assign raw[1] = flag_under && soft_done;
  assign raw[2] = soft_done && flag_reach && !flag_over && !flag_low;

  for (genvar i = 0; i < NF; i++) begin : g_filt
    logic [CW-1:0] cnt;
    logic          st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        st  <= 1'b0;
      end else if (clr || raw[i] == st) begin
        cnt <= '0;
        if (clr) st <= 1'b0;
      end else if (cnt == CW'(FILT - 1)) begin
        cnt <= '0;
        st  <= raw[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign q[i] = st;
  end

  logic ov_lat, uv_lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_lat <= 1'b0;
      uv_lat <= 1'b0;
    end else if (clr) begin
      ov_lat <= 1'b0;
      uv_lat <= 1'b0;
    end else begin
      if (q[0] && !uv_lat) ov_lat <= 1'b1;
      if (q[1] && !q[0] && !ov_lat) uv_lat <= 1'b1;
    end
  end

  assign ls_force_on  = ov_lat;
  assign drv_tristate = uv_lat;
  assign ctrl_off     = ov_lat || uv_lat;
  assign pgood        = q[2] && !ctrl_off;

  assert_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force_on && drv_tristate));

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_off && enable && supply_ok) |=> ctrl_off);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ctrl_off && !pgood));

  assert_pg_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(soft_done && flag_reach && !flag_over && !flag_low));
endmodule

// File: tb/sim_out_supervisor.sv
module sim_out_supervisor;
  localparam int PERIOD = 10;
  localparam int F = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, supply_ok = 1'b0, soft_done = 1'b0;
  logic flag_over = 1'b0, flag_low = 1'b0, flag_under = 1'b0, flag_reach = 1'b0;
  logic pgood, ls_force_on, drv_tristate, ctrl_off;

  int n_chk = 0, n_bad = 0;
  int mc[3];
  bit mq[3];
  bit m_ov, m_uv;

  always #(PERIOD / 2) clk = ~clk;

  out_supervisor #(.FILT(F)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_ok(supply_ok),
    .soft_done(soft_done), .flag_over(flag_over), .flag_low(flag_low),
    .flag_under(flag_under), .flag_reach(flag_reach), .pgood(pgood),
    .ls_force_on(ls_force_on), .drv_tristate(drv_tristate), .ctrl_off(ctrl_off)
  );

  function automatic bit raw_of(int i);
    case (i)
      0: return flag_over;
      1: return flag_under && soft_done;
      default: return soft_done && flag_reach && !flag_over && !flag_low;
    endcase
  endfunction

  task automatic model_edge();
    if (!rst_n || !enable || !supply_ok) begin
      for (int i = 0; i < 3; i++) begin mc[i] = 0; mq[i] = 0; end
      m_ov = 0; m_uv = 0;
    end else begin
      bit nov, nuv;
      nov = m_ov | (mq[0] & !m_uv);
      nuv = m_uv | (mq[1] & !mq[0] & !m_ov);
      for (int i = 0; i < 3; i++) begin
        bit r;
        r = raw_of(i);
        if (r == mq[i]) mc[i] = 0;
        else if (mc[i] == F - 1) begin mc[i] = 0; mq[i] = r; end
        else mc[i]++;
      end
      m_ov = nov; m_uv = nuv;
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic chk(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_all();
    enable = 1'b0; tick(1); enable = 1'b1;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk(pgood, 0, "R1 reset pgood");
    chk(ctrl_off, 0, "R1 reset ctrl_off");
    rst_n = 1'b1;
    tick(2);
    chk(pgood, 0, "R1 disabled pgood");
    enable = 1'b1; supply_ok = 1'b1; flag_reach = 1'b1; flag_under = 1'b1;
    tick(3 * F);
    chk(pgood, 0, "R2 no pgood before soft start");
    chk(drv_tristate, 0, "R7 under ignored before soft start");
    chk(ctrl_off, 0, "R7 ctrl_off before soft start");
    flag_under = 1'b0; soft_done = 1'b1;
    tick(F - 1);
    chk(pgood, 0, "R2 pgood one edge early");
    tick(1);
    chk(pgood, 1, "R2 pgood at edge FILT");
    flag_low = 1'b1; tick(F - 1); flag_low = 1'b0; tick(1);
    chk(pgood, 1, "R4 short dip ignored");
    flag_low = 1'b1; tick(F - 1);
    chk(pgood, 1, "R4 count restarted");
    tick(1);
    chk(pgood, 0, "R3 pgood drops at edge FILT");
    flag_low = 1'b0; tick(F);
    chk(pgood, 1, "R2 pgood recovers");
    flag_over = 1'b1; tick(F);
    chk(ls_force_on, 0, "R5 ov not yet latched");
    tick(1);
    chk(ls_force_on, 1, "R5 ov latched");
    chk(ctrl_off, 1, "R5 ctrl_off on ov");
    chk(drv_tristate, 0, "R5 no tristate on ov");
    flag_over = 1'b0; tick(3 * F);
    chk(ls_force_on, 1, "R9 ov held");
    chk(pgood, 0, "R9 pgood low while faulted");
    clear_all();
    chk(ctrl_off, 0, "R10 enable clears");
    chk(ls_force_on, 0, "R10 ov cleared");
    flag_under = 1'b1; flag_low = 1'b1; tick(F);
    chk(drv_tristate, 0, "R6 uv not yet latched");
    tick(1);
    chk(drv_tristate, 1, "R6 uv latched");
    chk(ls_force_on, 0, "R6 no low-side on uv");
    chk(ctrl_off, 1, "R6 ctrl_off on uv");
    supply_ok = 1'b0; tick(1); supply_ok = 1'b1;
    chk(drv_tristate, 0, "R10 lockout clears");
    flag_over = 1'b1; tick(F + 1);
    chk(ls_force_on, 1, "R8 ov wins");
    chk(drv_tristate, 0, "R8 uv suppressed");
    tick(F);
    chk(drv_tristate, 0, "R8 uv stays suppressed");
    flag_over = 1'b0; flag_under = 1'b0; flag_low = 1'b0;
    clear_all();

    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 15) == 0) begin
        flag_over  = ($urandom_range(0, 5) == 0);
        flag_low   = ($urandom_range(0, 3) == 0);
        flag_under = flag_low && ($urandom_range(0, 1) == 0);
        flag_reach = !flag_low || ($urandom_range(0, 1) == 0);
        soft_done  = ($urandom_range(0, 7) != 0);
      end
      enable    = ($urandom_range(0, 199) != 0);
      supply_ok = ($urandom_range(0, 299) != 0);
      tick(1);
      chk(pgood, mq[2] && !(m_ov || m_uv), "R2 R3 R4 random pgood");
      chk(ls_force_on, m_ov, "R5 R8 random ov");
      chk(drv_tristate, m_uv, "R6 R7 random uv");
      chk(ctrl_off, m_ov || m_uv, "R9 R10 random ctrl_off");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule